// File: doc/BRIEF.md
# Reset Controller with Configuration Strap Capture

This block merges two reset sources into one system reset: an active-low external reset pin and a watchdog reset request. The pin forces the system reset low at once, with no clock needed. Release always waits for the slow clock. The pin is first synchronized, and then the reset is held for a fixed number of extra cycles. A watchdog request enters through its own synchronizer and starts the same hold sequence.

Two configuration straps share pins with other functions. One selects the boot memory width. The other, when low, puts the chip into a mode where every output driver is disabled. The straps are read only while the external pin holds the chip in reset. The block keeps a short history of each strap and latches a strap on the pin's release edge, but only if it was steady across the whole history window. A watchdog reset never reloads the straps. A status output tells software which source caused the most recent reset.

Top module: `rst_strap_ctrl`

## Requirements
- R1: While `ext_rst_ni` is low, `sys_rst_no` is low. The assertion takes effect immediately, without waiting for a clock edge.
- R2: After `ext_rst_ni` rises, `sys_rst_no` rises on the 12th rising edge of `clk_slow_i`: 2 synchronizer stages plus 10 hold cycles. This holds even when the low pulse was only a few cycles long.
- R3: The boot-width strap latched at pin release appears on `boot_8bit_o`. A strap value of 1 selects 8-bit boot memory and gives 1. A value of 0 selects 16-bit boot memory and gives 0.
- R4: The tri-state strap is active low. A latched value of 0 drives `out_tristate_o` to 1, which disables all outputs. A latched value of 1 drives it to 0.
- R5: Only the last 10 synchronized strap samples taken before the pin release are considered. A strap that changes earlier in a long reset is still accepted.
- R6: If a strap is not constant across those 10 samples, its previously latched value is kept. Each strap is judged on its own.
- R7: If the pin is low for fewer cycles than the window needs, no strap is updated.
- R8: A watchdog request held across one clock edge drives `sys_rst_no` low on the 3rd edge. `sys_rst_no` rises again on the 13th edge, which is 10 hold cycles after the synchronized request clears.
- R9: A watchdog reset leaves `boot_8bit_o` and `out_tristate_o` unchanged, whatever the strap inputs are doing.
- R10: If the pin and the watchdog are active at the same time, the pin wins. The straps are sampled and the cause reads as pin.
- R11: `cause_wdog_o` is 1 after a watchdog reset and 0 after a pin reset. It holds that value after the system reset releases.
- R12: While the pin is held low, `sys_rst_no` is 0 and `cause_wdog_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow_i | input | 1 | Slow reference clock |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| wdog_req_i | input | 1 | Watchdog reset request, active high |
| strap_boot_i | input | 1 | Boot width strap (1 = 8-bit, 0 = 16-bit) |
| strap_tri_ni | input | 1 | Tri-state strap, active low |
| sys_rst_no | output | 1 | System reset, active low |
| out_tristate_o | output | 1 | 1 = all output drivers disabled |
| boot_8bit_o | output | 1 | Latched boot width (1 = 8-bit) |
| cause_wdog_o | output | 1 | Last reset cause (1 = watchdog, 0 = pin) |

## Verification
A watchdog request and an external pin reset can fall in the same cycle. The pin has to win: it clears the synchronized request, forces the cause to pin, and still reloads the straps. The bench raises both inputs on the same drive step and holds the pin low for a full window with new strap values. It then expects the new straps and a pin cause, and it also expects a clean release 12 edges after the pin rises. A separate pass uses a watchdog-only reset while the strap inputs are changing, and judges that the latched outputs stay the same.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  typedef enum logic {
    CAUSE_PIN  = 1'b0,
    CAUSE_WDOG = 1'b1
  } cause_e;

  localparam int unsigned STRAP_BOOT = 0;
  localparam int unsigned STRAP_TRI  = 1;
  localparam int unsigned NUM_STRAPS = 2;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int unsigned HOLD = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic rel_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (hold_i) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (!done_q) begin
      if (cnt_q == CW'(HOLD - 1)) begin
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign rel_o = done_q;

  // R8
  hold_forces_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !rel_o);
endmodule

// File: rtl/rstc_strap_win.sv
module rstc_strap_win #(
  parameter int unsigned SYNC = 2,
  parameter int unsigned WIN  = 10
) (
  input  logic clk_i,
  input  logic smp_i,
  input  logic clr_i,
  input  logic load_i,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned FW = $clog2(WIN + 1);

  logic [SYNC-1:0] sy_q, sy_d;
  logic [WIN-1:0]  hist_q, hist_d;
  logic [FW-1:0]   fill_q, fill_d;
  logic            lat_q, lat_d;
  logic            steady;

  always_comb begin
    sy_d   = {sy_q[SYNC-2:0], d_i};
    hist_d = hist_q;
    fill_d = fill_q;
    if (smp_i) begin
      hist_d = {hist_q[WIN-2:0], sy_q[SYNC-1]};
    end
    if (clr_i) begin
      fill_d = '0;
    end else if (smp_i && (fill_q != FW'(WIN))) begin
      fill_d = fill_q + 1'b1;
    end
    steady = (fill_q == FW'(WIN)) && ((hist_q == '0) || (hist_q == '1));
    lat_d  = (load_i && steady) ? hist_q[0] : lat_q;
  end

  // Sampler runs while the chip is held in reset, so it has no reset itself.
  always_ff @(posedge clk_i) begin
    sy_q   <= sy_d;
    hist_q <= hist_d;
    fill_q <= fill_d;
    lat_q  <= lat_d;
  end

  assign q_o = lat_q;
endmodule

// File: rtl/rst_strap_ctrl.sv
module rst_strap_ctrl
  import rstc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYCLES = 10,
  parameter int unsigned WIN_CYCLES  = 10
) (
  input  logic clk_slow_i,
  input  logic ext_rst_ni,
  input  logic wdog_req_i,
  input  logic strap_boot_i,
  input  logic strap_tri_ni,
  output logic sys_rst_no,
  output logic out_tristate_o,
  output logic boot_8bit_o,
  output logic cause_wdog_o
);
  localparam int unsigned LRW = $clog2(HOLD_CYCLES + 1);

  logic                  pin_ok, pin_ok_q;
  logic                  wdog_s;
  logic                  rel_edge;
  logic                  hold;
  logic                  rel_n;
  cause_e                cause_q, cause_d;
  logic [NUM_STRAPS-1:0] strap_raw;
  logic [NUM_STRAPS-1:0] strap_q;

  rstc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) pin_sync_i (
    .clk_i (clk_slow_i),
    .rst_ni(ext_rst_ni),
    .d_i   (1'b1),
    .q_o   (pin_ok)
  );

  rstc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) wdog_sync_i (
    .clk_i (clk_slow_i),
    .rst_ni(ext_rst_ni),
    .d_i   (wdog_req_i),
    .q_o   (wdog_s)
  );

  always_ff @(posedge clk_slow_i or negedge ext_rst_ni) begin
    if (!ext_rst_ni) begin
      pin_ok_q <= 1'b0;
    end else begin
      pin_ok_q <= pin_ok;
    end
  end

  assign rel_edge = pin_ok & ~pin_ok_q;
  assign hold     = wdog_s | ~pin_ok;

  rstc_stretch #(.HOLD(HOLD_CYCLES)) stretch_i (
    .clk_i (clk_slow_i),
    .rst_ni(ext_rst_ni),
    .hold_i(hold),
    .rel_o (rel_n)
  );

  always_comb begin
    cause_d = cause_q;
    if (wdog_s) begin
      cause_d = CAUSE_WDOG;
    end
  end

  always_ff @(posedge clk_slow_i or negedge ext_rst_ni) begin
    if (!ext_rst_ni) begin
      cause_q <= CAUSE_PIN;
    end else begin
      cause_q <= cause_d;
    end
  end

  assign strap_raw[STRAP_BOOT] = strap_boot_i;
  assign strap_raw[STRAP_TRI]  = strap_tri_ni;

  for (genvar s = 0; s < NUM_STRAPS; s++) begin : g_strap
    rstc_strap_win #(.SYNC(SYNC_STAGES), .WIN(WIN_CYCLES)) win_i (
      .clk_i (clk_slow_i),
      .smp_i (~pin_ok),
      .clr_i (pin_ok),
      .load_i(rel_edge),
      .d_i   (strap_raw[s]),
      .q_o   (strap_q[s])
    );
  end

  assign sys_rst_no     = rel_n;
  assign boot_8bit_o    = strap_q[STRAP_BOOT];
  assign out_tristate_o = ~strap_q[STRAP_TRI];
  assign cause_wdog_o   = (cause_q == CAUSE_WDOG);

  // Checker: length of the current low phase of the system reset.
  logic [LRW-1:0] low_run_q;
  always_ff @(posedge clk_slow_i or negedge ext_rst_ni) begin
    if (!ext_rst_ni) begin
      low_run_q <= '0;
    end else if (sys_rst_no) begin
      low_run_q <= '0;
    end else if (low_run_q != LRW'(HOLD_CYCLES)) begin
      low_run_q <= low_run_q + 1'b1;
    end
  end

  // R2
  min_hold_chk: assert property (@(posedge clk_slow_i) disable iff (!ext_rst_ni)
    $rose(sys_rst_no) |-> (low_run_q == LRW'(HOLD_CYCLES)));

  // R9
  strap_only_on_release_chk: assert property (@(posedge clk_slow_i) disable iff (!ext_rst_ni)
    !rel_edge |=> $stable(strap_q));

  // R11
  wdog_cause_chk: assert property (@(posedge clk_slow_i) disable iff (!ext_rst_ni)
    wdog_s |=> cause_wdog_o);

  // R8
  wdog_resets_chk: assert property (@(posedge clk_slow_i) disable iff (!ext_rst_ni)
    wdog_s |=> !sys_rst_no);
endmodule

// File: tb/rst_strap_ctrl_tb_top.sv
module rst_strap_ctrl_tb_top;
  logic clk = 1'b0;
  logic pin_n, wdog, s_boot, s_tri_n;
  logic rst_n, tri_o, boot_o, cause_o;

  always #10 clk = ~clk;

  rst_strap_ctrl dut_i (
    .clk_slow_i    (clk),
    .ext_rst_ni    (pin_n),
    .wdog_req_i    (wdog),
    .strap_boot_i  (s_boot),
    .strap_tri_ni  (s_tri_n),
    .sys_rst_no    (rst_n),
    .out_tristate_o(tri_o),
    .boot_8bit_o   (boot_o),
    .cause_wdog_o  (cause_o)
  );

  typedef struct {
    string tag;
    logic  rst;
    logic  boot;
    logic  tri_st;
    logic  cause;
    bit    straps;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  logic m_boot, m_tri, m_cause;

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic push(string tag, logic r, bit straps);
    exp_t e;
    e.tag = tag; e.rst = r; e.boot = m_boot; e.tri_st = m_tri;
    e.cause = m_cause; e.straps = straps;
    exp_q.push_back(e);
  endtask

  // Monitor: compares queued expectations away from the active edge.
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk({e.tag, " rst"}, rst_n, e.rst);
      chk({e.tag, " cause"}, cause_o, e.cause);
      if (e.straps) begin
        chk({e.tag, " boot"}, boot_o, e.boot);
        chk({e.tag, " tri"}, tri_o, e.tri_st);
      end
    end
  end

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Release the pin and check the release lands on the 12th edge (R2).
  task automatic release_pin(string tag);
    pin_n = 1'b1;
    edges(11);
    push({tag, " R2 still low"}, 1'b0, 1'b1);
    edges(1);
    push({tag, " R2 released"}, 1'b1, 1'b1);
    edges(2);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual running expected done");
    finish_run();
  end

  initial begin
    pin_n = 1'b0; wdog = 1'b0; s_boot = 1'b1; s_tri_n = 1'b1;
    m_cause = 1'b0; m_boot = 1'b1; m_tri = 1'b0;
    edges(20);
    // R12 reset state
    push("R12 reset state", 1'b0, 1'b0);
    edges(1);
    // R3 R4 first load: 8-bit boot, normal outputs
    release_pin("R3 R4 load 8bit normal");

    // R1 asynchronous assertion
    s_boot = 1'b0; s_tri_n = 1'b0;
    #4 pin_n = 1'b0;
    #1 chk("R1 async assert", rst_n, 1'b0);
    edges(20);
    m_boot = 1'b0; m_tri = 1'b1;
    release_pin("R3 R4 load 16bit tristate");

    // R5 glitch early in a long reset is outside the window
    pin_n = 1'b0; s_boot = 1'b1; s_tri_n = 1'b1;
    edges(15);
    s_boot = 1'b0;
    edges(2);
    s_boot = 1'b1;
    edges(23);
    m_boot = 1'b1; m_tri = 1'b0;
    release_pin("R5 early glitch accepted");

    // R6 glitch inside the window: boot kept, tri accepted
    pin_n = 1'b0; s_boot = 1'b0; s_tri_n = 1'b0;
    edges(25);
    s_boot = 1'b1;
    edges(2);
    s_boot = 1'b0;
    edges(3);
    m_boot = 1'b1; m_tri = 1'b1;
    release_pin("R6 unstable kept");

    // R7 short pulse: straps not reloaded, full hold still applies
    pin_n = 1'b0; s_boot = 1'b0; s_tri_n = 1'b1;
    edges(3);
    release_pin("R7 short pulse");

    // R8 R9 R11 watchdog reset
    s_boot = 1'b0; s_tri_n = 1'b1;
    wdog = 1'b1;
    edges(1);
    wdog = 1'b0;
    s_boot = 1'b1;
    edges(2);
    m_cause = 1'b1;
    push("R8 R11 wdog asserts", 1'b0, 1'b1);
    s_boot = 1'b0;
    edges(9);
    push("R8 wdog still low", 1'b0, 1'b1);
    edges(1);
    push("R8 R9 wdog released straps kept", 1'b1, 1'b1);
    edges(5);
    push("R11 cause held", 1'b1, 1'b1);
    edges(1);

    // R10 coincident pin and watchdog
    s_boot = 1'b0; s_tri_n = 1'b1;
    wdog = 1'b1; pin_n = 1'b0;
    edges(1);
    m_cause = 1'b0;
    push("R10 R12 pin wins cause", 1'b0, 1'b1);
    edges(19);
    wdog = 1'b0;
    edges(1);
    m_boot = 1'b0; m_tri = 1'b0;
    release_pin("R10 straps sampled");
    push("R11 cause pin", 1'b1, 1'b1);
    edges(2);
    finish_run();
  end
endmodule